// File: doc/BRIEF.md
# Memory PHY Bring-Up Sequencer

This block is a synchronous controller that takes a memory PHY from power-on through reset, driver flush, impedance calibration, DLL calibration, clock-alignment lock and duty-cycle calibration. It drives the PHY's control lines directly and waits for fixed, parameterised cycle counts between steps. Its status inputs report impedance-cal completion, the DLL result, rotator lock on the data and address groups, duty-cycle completion and a vector of alarm flags. The analog PHY, the calibration engines and any register bus are outside the block and appear only as these inputs.

A one-cycle `start` pulse launches a run. When no memory is fitted, the run finishes at once with no other effect. Otherwise the run ends in `done` or in `fail` with a 4-bit code that names the phase that broke. The alarm flags are examined once at the end of every run, whether it succeeded or failed. Alarm reporting is unmasked only after a clean run.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset all outputs are idle: `dll_cal_reset`=1, `align_rst`=1, `rot_cfg`=16'h0000, and every other output (including `busy`, `done`, `fail`, `fail_code`) is 0.
- R2: A `start` pulse while not busy with `mem_present`=0 makes `done`=1 in the next cycle. No PHY control output ever leaves its idle value during that run.
- R3: A run with memory raises `clk_hold_low` in the cycle after `start`. It stays high until the post-exit wait of R10 ends.
- R4: `phy_reset` is high for exactly RST_CYC consecutive cycles.
- R5: `flush` and `io_init` are always equal and are high for exactly FLUSH_CYC cycles.
- R6: `imp_cal_en` is high for exactly ZCAL_CYC cycles, after which `imp_cal_done` is polled. If it stays low for TMO_CYC cycles, the run fails with code 1.
- R7: Releasing `dll_cal_reset` starts DLL polling on `dll_stat`. The priority is bit2 > bit1 > bit0. Bit2 fails the run with code 3. Bit1 raises `dll_wa` for exactly WA_CYC cycles and then continues. Bit0 continues directly. If no bit is set within TMO_CYC cycles, the run fails with code 2.
- R8: `rot_cfg` is 16'h8060 (continuous update) for ROT_CYC cycles, then both `rot_lock_data` and `rot_lock_addr` are polled. If both are not high within TMO_CYC cycles, the run fails with code 4.
- R9: `align_rst` falls only in the cycle after both lock inputs were seen high. `rd_offset_clr` is a single-cycle pulse that comes in the cycle after `align_rst` fell.
- R10: `rot_cfg` then becomes 16'h8020 for POST_CYC cycles with `clk_hold_low` still high, and `clk_hold_low` drops right after.
- R11: `duty_cal_start` is raised only after `clk_hold_low` dropped and is held until `duty_cal_done`. If done does not arrive within TMO_CYC cycles, the run fails with code 5.
- R12: `alarm_check` pulses exactly once at the end of every run, on success and on each failure. Nonzero `alarm_flags` at that check on an otherwise clean run gives code 6.
- R13: `alarm_unmask` pulses once, only on a fully clean run, and is followed by `done`. `done`, `fail` and `fail_code` hold until the next `start`, and a new run may start from either end state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the sequence |
| mem_present | input | 1 | 1 when memory is fitted |
| imp_cal_done | input | 1 | Impedance calibration finished |
| dll_stat | input | 3 | DLL result: bit0 good, bit1 needs workaround, bit2 error |
| rot_lock_data | input | 1 | Data-group rotator locked |
| rot_lock_addr | input | 1 | Address-group rotator locked |
| duty_cal_done | input | 1 | Duty-cycle calibration finished |
| alarm_flags | input | ERR_W | Alarm flags examined at the final check |
| phy_reset | output | 1 | PHY reset, active high |
| flush | output | 1 | Output-driver flush |
| io_init | output | 1 | I/O initialise, paired with flush |
| imp_cal_en | output | 1 | Impedance controller enable |
| dll_cal_reset | output | 1 | DLL calibration reset, released to calibrate |
| dll_wa | output | 1 | DLL workaround step active |
| rot_cfg | output | 16 | Rotator control word |
| align_rst | output | 1 | Clock-alignment reset |
| rd_offset_clr | output | 1 | Read-delay offset clear pulse |
| clk_hold_low | output | 1 | Hold memory clock low |
| duty_cal_start | output | 1 | Duty-cycle calibration request |
| alarm_check | output | 1 | Final alarm check strobe |
| alarm_unmask | output | 1 | Unmask alarms after success |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended successfully (or skipped) |
| fail | output | 1 | Run ended in failure |
| fail_code | output | 4 | Failing phase, valid while `fail` |

## Verification
The hardest paths to reach from the ports are the failure exits deep in the run: a lock timeout, a duty-cycle timeout, and an alarm raised only at the final check. Each must still pass through the alarm check without ever unmasking. The bench reaches them by holding one status input at its failing value for a whole run while the others report success. Short wait and timeout parameters let each run finish in tens of cycles. Per-output monitors count the high cycles and order violations (clear before alignment release, duty-cycle request while the clock is held). The DLL priority is exercised by asserting all three status bits at once.

// File: rtl/phybr_pkg.sv
package phybr_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_SKIP, ST_PREP, ST_RST, ST_FLUSH, ST_ZCAL, ST_ZCHK,
    ST_DLL, ST_DLLWA, ST_ROTCU, ST_LOCK, ST_ALIGN, ST_RDCLR, ST_ROTOFF,
    ST_DUTY, ST_ACHK, ST_UNMASK, ST_DONE, ST_FAIL
  } phase_e;

  localparam logic [3:0] FC_NONE   = 4'd0;
  localparam logic [3:0] FC_ZCAL   = 4'd1;
  localparam logic [3:0] FC_DLLTMO = 4'd2;
  localparam logic [3:0] FC_DLLERR = 4'd3;
  localparam logic [3:0] FC_LOCK   = 4'd4;
  localparam logic [3:0] FC_DUTY   = 4'd5;
  localparam logic [3:0] FC_ALARM  = 4'd6;

  localparam logic [15:0] ROT_CONT = 16'h8060;
  localparam logic [15:0] ROT_EXIT = 16'h8020;

  typedef struct packed {
    logic        phy_reset;
    logic        flush;
    logic        io_init;
    logic        imp_cal_en;
    logic        dll_cal_reset;
    logic        dll_wa;
    logic [15:0] rot_cfg;
    logic        align_rst;
    logic        rd_offset_clr;
    logic        clk_hold_low;
    logic        duty_cal_start;
    logic        alarm_check;
    logic        alarm_unmask;
    logic        busy;
    logic        done;
    logic        fail;
  } phy_ctl_t;

  // Counter preload so that a phase lasts exactly n cycles.
  function automatic int span_load(input int n);
    return (n > 1) ? n - 1 : 0;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/phybr_timer.sv
module phybr_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/phybr_outdec.sv
module phybr_outdec
  import phybr_pkg::*;
(
  input  phase_e   st,
  input  logic     clean,
  output phy_ctl_t ctl
);
  always_comb begin
    ctl = '0;
    ctl.dll_cal_reset = 1'b1;
    ctl.align_rst     = 1'b1;
    ctl.busy          = !(st inside {ST_IDLE, ST_SKIP, ST_DONE, ST_FAIL});
    case (st)
      ST_SKIP:  ctl.done = 1'b1;
      ST_FAIL:  ctl.fail = 1'b1;
      ST_PREP, ST_ZCHK: ctl.clk_hold_low = 1'b1;
      ST_RST: begin
        ctl.clk_hold_low = 1'b1;
        ctl.phy_reset    = 1'b1;
      end
      ST_FLUSH: begin
        ctl.clk_hold_low = 1'b1;
        ctl.flush        = 1'b1;
        ctl.io_init      = 1'b1;
      end
      ST_ZCAL: begin
        ctl.clk_hold_low = 1'b1;
        ctl.imp_cal_en   = 1'b1;
      end
      ST_DLL, ST_DLLWA: begin
        ctl.clk_hold_low  = 1'b1;
        ctl.dll_cal_reset = 1'b0;
        ctl.dll_wa        = (st == ST_DLLWA);
      end
      ST_ROTCU, ST_LOCK, ST_ALIGN, ST_RDCLR: begin
        ctl.clk_hold_low  = 1'b1;
        ctl.dll_cal_reset = 1'b0;
        ctl.rot_cfg       = ROT_CONT;
        ctl.align_rst     = !(st inside {ST_ALIGN, ST_RDCLR});
        ctl.rd_offset_clr = (st == ST_RDCLR);
      end
      ST_ROTOFF: begin
        ctl.clk_hold_low  = 1'b1;
        ctl.dll_cal_reset = 1'b0;
        ctl.align_rst     = 1'b0;
        ctl.rot_cfg       = ROT_EXIT;
      end
      ST_DUTY, ST_UNMASK, ST_DONE: begin
        ctl.dll_cal_reset  = 1'b0;
        ctl.align_rst      = 1'b0;
        ctl.rot_cfg        = ROT_EXIT;
        ctl.duty_cal_start = (st == ST_DUTY);
        ctl.alarm_unmask   = (st == ST_UNMASK);
        ctl.done           = (st == ST_DONE);
      end
      ST_ACHK: begin
        ctl.alarm_check = 1'b1;
        if (clean) begin
          ctl.dll_cal_reset = 1'b0;
          ctl.align_rst     = 1'b0;
          ctl.rot_cfg       = ROT_EXIT;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phybr_pkg::*;
#(
  parameter int RST_CYC   = 32,
  parameter int FLUSH_CYC = 32,
  parameter int ZCAL_CYC  = 1024,
  parameter int ROT_CYC   = 5932,
  parameter int POST_CYC  = 32,
  parameter int WA_CYC    = 16,
  parameter int TMO_CYC   = 4096,
  parameter int ERR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mem_present,
  input  logic             imp_cal_done,
  input  logic [2:0]       dll_stat,
  input  logic             rot_lock_data,
  input  logic             rot_lock_addr,
  input  logic             duty_cal_done,
  input  logic [ERR_W-1:0] alarm_flags,
  output logic             phy_reset,
  output logic             flush,
  output logic             io_init,
  output logic             imp_cal_en,
  output logic             dll_cal_reset,
  output logic             dll_wa,
  output logic [15:0]      rot_cfg,
  output logic             align_rst,
  output logic             rd_offset_clr,
  output logic             clk_hold_low,
  output logic             duty_cal_start,
  output logic             alarm_check,
  output logic             alarm_unmask,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [3:0]       fail_code
);
  localparam int MAXW  = max2(max2(max2(RST_CYC, FLUSH_CYC), max2(ZCAL_CYC, ROT_CYC)),
                              max2(max2(POST_CYC, WA_CYC), TMO_CYC));
  localparam int CNT_W = $clog2(MAXW + 1);

  localparam logic [CNT_W-1:0] LD_RST   = CNT_W'(span_load(RST_CYC));
  localparam logic [CNT_W-1:0] LD_FLUSH = CNT_W'(span_load(FLUSH_CYC));
  localparam logic [CNT_W-1:0] LD_ZCAL  = CNT_W'(span_load(ZCAL_CYC));
  localparam logic [CNT_W-1:0] LD_ROT   = CNT_W'(span_load(ROT_CYC));
  localparam logic [CNT_W-1:0] LD_POST  = CNT_W'(span_load(POST_CYC));
  localparam logic [CNT_W-1:0] LD_WA    = CNT_W'(span_load(WA_CYC));
  localparam logic [CNT_W-1:0] LD_TMO   = CNT_W'(span_load(TMO_CYC));

  phase_e           st, st_nx;
  logic [3:0]       pend, pend_nx;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             span_end;
  logic             both_locked;
  phy_ctl_t         ctl;

  assign both_locked = rot_lock_data && rot_lock_addr;

  phybr_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .expired(span_end)
  );

  always_comb begin
    st_nx   = st;
    pend_nx = pend;
    ld      = 1'b0;
    ld_val  = '0;
    case (st)
      ST_IDLE, ST_SKIP, ST_DONE, ST_FAIL:
        if (start) begin
          pend_nx = FC_NONE;
          st_nx   = mem_present ? ST_PREP : ST_SKIP;
        end
      ST_PREP: begin st_nx = ST_RST; ld = 1'b1; ld_val = LD_RST; end
      ST_RST:
        if (span_end) begin st_nx = ST_FLUSH; ld = 1'b1; ld_val = LD_FLUSH; end
      ST_FLUSH:
        if (span_end) begin st_nx = ST_ZCAL; ld = 1'b1; ld_val = LD_ZCAL; end
      ST_ZCAL:
        if (span_end) begin st_nx = ST_ZCHK; ld = 1'b1; ld_val = LD_TMO; end
      ST_ZCHK:
        if (imp_cal_done) begin st_nx = ST_DLL; ld = 1'b1; ld_val = LD_TMO; end
        else if (span_end) begin st_nx = ST_ACHK; pend_nx = FC_ZCAL; end
      ST_DLL:
        if (dll_stat[2])      begin st_nx = ST_ACHK; pend_nx = FC_DLLERR; end
        else if (dll_stat[1]) begin st_nx = ST_DLLWA; ld = 1'b1; ld_val = LD_WA; end
        else if (dll_stat[0]) begin st_nx = ST_ROTCU; ld = 1'b1; ld_val = LD_ROT; end
        else if (span_end)    begin st_nx = ST_ACHK; pend_nx = FC_DLLTMO; end
      ST_DLLWA:
        if (span_end) begin st_nx = ST_ROTCU; ld = 1'b1; ld_val = LD_ROT; end
      ST_ROTCU:
        if (span_end) begin st_nx = ST_LOCK; ld = 1'b1; ld_val = LD_TMO; end
      ST_LOCK:
        if (both_locked)   st_nx = ST_ALIGN;
        else if (span_end) begin st_nx = ST_ACHK; pend_nx = FC_LOCK; end
      ST_ALIGN: st_nx = ST_RDCLR;
      ST_RDCLR: begin st_nx = ST_ROTOFF; ld = 1'b1; ld_val = LD_POST; end
      ST_ROTOFF:
        if (span_end) begin st_nx = ST_DUTY; ld = 1'b1; ld_val = LD_TMO; end
      ST_DUTY:
        if (duty_cal_done) st_nx = ST_ACHK;
        else if (span_end) begin st_nx = ST_ACHK; pend_nx = FC_DUTY; end
      ST_ACHK:
        if (pend != FC_NONE)      st_nx = ST_FAIL;
        else if (|alarm_flags)    begin st_nx = ST_FAIL; pend_nx = FC_ALARM; end
        else                      st_nx = ST_UNMASK;
      ST_UNMASK: st_nx = ST_DONE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      pend <= FC_NONE;
    end else begin
      st   <= st_nx;
      pend <= pend_nx;
    end
  end

  phybr_outdec u_dec (.st(st), .clean(pend == FC_NONE), .ctl(ctl));

  assign phy_reset      = ctl.phy_reset;
  assign flush          = ctl.flush;
  assign io_init        = ctl.io_init;
  assign imp_cal_en     = ctl.imp_cal_en;
  assign dll_cal_reset  = ctl.dll_cal_reset;
  assign dll_wa         = ctl.dll_wa;
  assign rot_cfg        = ctl.rot_cfg;
  assign align_rst      = ctl.align_rst;
  assign rd_offset_clr  = ctl.rd_offset_clr;
  assign clk_hold_low   = ctl.clk_hold_low;
  assign duty_cal_start = ctl.duty_cal_start;
  assign alarm_check    = ctl.alarm_check;
  assign alarm_unmask   = ctl.alarm_unmask;
  assign busy           = ctl.busy;
  assign done           = ctl.done;
  assign fail           = ctl.fail;
  assign fail_code      = ctl.fail ? pend : FC_NONE;

  // R2
  skip_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mem_present && !busy) |=> (done && !clk_hold_low));

  // R7
  dll_wa_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_wa) |-> $past(dll_stat[1] && !dll_stat[2]));

  // R9
  align_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(align_rst) |-> $past(rot_lock_data && rot_lock_addr));

  // R9
  rdclr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_offset_clr |-> ($past(!align_rst) && !$past(rd_offset_clr)));

  // R10
  clk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clk_hold_low) && !align_rst) |-> ($past(rot_cfg) == ROT_EXIT));

  // R12
  fail_via_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(alarm_check));

  // R13
  unmask_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_unmask |-> ($past(alarm_check) && ($past(alarm_flags) == '0)));

  // R13
  unmask_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_unmask |=> done);

  // R13
  code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (fail_code != FC_NONE));
endmodule

// File: tb/sim_phy_bringup_seq.sv
module sim_phy_bringup_seq;
  localparam int RST = 4, FL = 5, ZC = 8, ROT = 12, POST = 6, WA = 3, TMO = 20;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mem_present = 1'b1;
  logic imp_cal_done = 1'b1, rot_lock_data = 1'b1, rot_lock_addr = 1'b1, duty_cal_done = 1'b1;
  logic [2:0] dll_stat = 3'b001;
  logic [7:0] alarm_flags = 8'h00;
  logic phy_reset, flush, io_init, imp_cal_en, dll_cal_reset, dll_wa, align_rst;
  logic rd_offset_clr, clk_hold_low, duty_cal_start, alarm_check, alarm_unmask;
  logic busy, done, fail;
  logic [15:0] rot_cfg;
  logic [3:0] fail_code;

  int n_chk = 0, n_bad = 0;
  bit mon = 0;
  int c_rst, c_fl, c_flmis, c_zc, c_wa, c_cont, c_exit, c_rdclr, c_rdbad;
  int c_duty, c_dutyhold, c_achk, c_unm, c_alow, c_dllrel;
  bit first_hold, first_done;

  always #5 clk = ~clk;

  phy_bringup_seq #(.RST_CYC(RST), .FLUSH_CYC(FL), .ZCAL_CYC(ZC), .ROT_CYC(ROT),
    .POST_CYC(POST), .WA_CYC(WA), .TMO_CYC(TMO), .ERR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_present(mem_present),
    .imp_cal_done(imp_cal_done), .dll_stat(dll_stat), .rot_lock_data(rot_lock_data),
    .rot_lock_addr(rot_lock_addr), .duty_cal_done(duty_cal_done), .alarm_flags(alarm_flags),
    .phy_reset(phy_reset), .flush(flush), .io_init(io_init), .imp_cal_en(imp_cal_en),
    .dll_cal_reset(dll_cal_reset), .dll_wa(dll_wa), .rot_cfg(rot_cfg), .align_rst(align_rst),
    .rd_offset_clr(rd_offset_clr), .clk_hold_low(clk_hold_low), .duty_cal_start(duty_cal_start),
    .alarm_check(alarm_check), .alarm_unmask(alarm_unmask), .busy(busy), .done(done),
    .fail(fail), .fail_code(fail_code));

  always @(negedge clk) if (mon) begin
    c_rst   += phy_reset;
    c_fl    += flush;
    c_flmis += (flush != io_init);
    c_zc    += imp_cal_en;
    c_wa    += dll_wa;
    c_cont  += (rot_cfg == 16'h8060);
    c_exit  += (rot_cfg == 16'h8020 && clk_hold_low);
    c_rdclr += rd_offset_clr;
    c_rdbad += (rd_offset_clr && align_rst);
    c_duty  += duty_cal_start;
    c_dutyhold += (duty_cal_start && clk_hold_low);
    c_achk  += alarm_check;
    c_unm   += alarm_unmask;
    c_alow  += !align_rst;
    c_dllrel += !dll_cal_reset;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input bit mp, input bit zc, input logic [2:0] ds, input bit ld,
                     input bit la, input bit dd, input logic [7:0] af);
    mem_present = mp; imp_cal_done = zc; dll_stat = ds; rot_lock_data = ld;
    rot_lock_addr = la; duty_cal_done = dd; alarm_flags = af;
    c_rst = 0; c_fl = 0; c_flmis = 0; c_zc = 0; c_wa = 0; c_cont = 0; c_exit = 0;
    c_rdclr = 0; c_rdbad = 0; c_duty = 0; c_dutyhold = 0; c_achk = 0; c_unm = 0;
    c_alow = 0; c_dllrel = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    first_hold = clk_hold_low; first_done = done;
    #1 mon = 1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (done || fail) break;
    end
    #1 mon = 0;
  endtask

  task automatic t_reset;
    chk(!busy && !done && !fail && fail_code == 0, "R1 status", {busy, done, fail}, 0);
    chk(dll_cal_reset && align_rst && rot_cfg == 0, "R1 resets", rot_cfg, 0);
    chk(!phy_reset && !flush && !io_init && !imp_cal_en && !clk_hold_low && !alarm_unmask,
        "R1 ctl idle", clk_hold_low, 0);
  endtask

  task automatic t_skip;
    run(0, 1, 3'b001, 1, 1, 1, 0);
    chk(first_done, "R2 done next cycle", first_done, 1);
    chk(!first_hold, "R2 no clock hold", first_hold, 0);
    repeat (3) @(negedge clk);
    chk(done && !busy && !clk_hold_low && !phy_reset && align_rst && dll_cal_reset,
        "R2 no step", busy, 0);
  endtask

  task automatic t_nominal;
    run(1, 1, 3'b001, 1, 1, 1, 0);
    chk(first_hold, "R3 hold after start", first_hold, 1);
    chk(c_rst == RST, "R4 reset length", c_rst, RST);
    chk(c_fl == FL && c_flmis == 0, "R5 flush length", c_fl, FL);
    chk(c_zc == ZC, "R6 imp cal length", c_zc, ZC);
    chk(c_wa == 0, "R7 no workaround", c_wa, 0);
    chk(c_cont == ROT + 3, "R8 continuous span", c_cont, ROT + 3);
    chk(c_rdclr == 1 && c_rdbad == 0, "R9 clear pulse", c_rdclr, 1);
    chk(c_exit == POST, "R10 exit wait", c_exit, POST);
    chk(c_duty == 1 && c_dutyhold == 0, "R11 duty start", c_duty, 1);
    chk(c_achk == 1, "R12 check once", c_achk, 1);
    chk(c_unm == 1 && done && !fail, "R13 unmask once", c_unm, 1);
    chk(rot_cfg == 16'h8020 && !clk_hold_low && !align_rst, "R10 final state", rot_cfg, 16'h8020);
  endtask

  task automatic t_fail(input string req, input bit zc, input logic [2:0] ds, input bit la,
                        input bit dd, input logic [7:0] af, input int code);
    run(1, zc, ds, 1, la, dd, af);
    chk(fail && !done, {req, " fail"}, fail, 1);
    chk(fail_code == code, {req, " code"}, fail_code, code);
    chk(c_achk == 1 && c_unm == 0, {req, " check no unmask"}, c_unm, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_skip();
    t_nominal();
    run(1, 1, 3'b010, 1, 1, 1, 0);
    chk(c_wa == WA && done, "R7 workaround length", c_wa, WA);
    t_fail("R7 priority", 1, 3'b111, 1, 1, 0, 3);
    chk(c_wa == 0, "R7 priority no workaround", c_wa, 0);
    t_fail("R7 timeout", 1, 3'b000, 1, 1, 0, 2);
    t_fail("R6 timeout", 0, 3'b001, 1, 1, 0, 1);
    chk(c_dllrel == 0, "R6 dll held", c_dllrel, 0);
    t_fail("R8 lock timeout", 1, 3'b001, 0, 1, 0, 4);
    chk(c_alow == 0 && c_rdclr == 0, "R9 no release without lock", c_alow, 0);
    t_fail("R11 timeout", 1, 3'b001, 1, 0, 0, 5);
    t_fail("R12 alarm", 1, 3'b001, 1, 1, 8'h10, 6);
    repeat (4) @(negedge clk);
    chk(fail && fail_code == 6, "R13 fail held", fail_code, 6);
    run(1, 1, 3'b001, 1, 1, 1, 0);
    chk(done && fail_code == 0, "R13 restart", fail_code, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule